// File: doc/BRIEF.md
# Shared System Bus Arbitration Cluster

This block arbitrates one shared system bus among several local bus masters. Each master has its own arbitration unit. A unit raises a bus request when its master asks for the bus. It takes the bus only when it holds top priority and the shared occupancy line shows the bus is free. Once it owns the bus it pulls that line low, so no other unit can take the bus. Every step is registered on the single bus clock. The priority inputs are combinational functions of registered requests, so they have a full cycle to settle.

The occupancy line is active low and models an open-drain wire, so it is the AND of every unit's drive. Priority is fixed: master 0 is highest. With the default daisy-chain variant, each unit passes priority to the next lower unit only while it is not requesting. A parameter selects a parallel encoder instead, which gives priority only to the lowest-indexed requester. A unit that gains priority cannot take the bus from the current owner. It waits until the owner finishes its transaction and releases the line. An owner that still has priority at the end of a transaction keeps the bus for as long as its master keeps requesting.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While reset is asserted, or asynchronously on its assertion, `breq` and `grant` are all zero and `busy_n` is 1.
- R2: A unit's `breq` bit rises on the first clock edge that samples its `loc_req` bit high while the unit is idle. `breq` stays high until the unit returns to idle.
- R3: `grant` has at most one bit set. Whenever any `grant` bit is 1, `busy_n` is 0.
- R4: A requesting unit with its `prio_ok` bit high gets its `grant` bit on the next edge when `busy_n` is 1 at that edge.
- R5: A unit without the bus that sees `busy_n` at 0 on an edge does not get `grant` on that edge, even if it holds priority.
- R6: An owner that has lost priority keeps `grant` and holds `busy_n` at 0 until an edge on which its `xfer_done` bit is 1.
- R7: An owner that still holds priority ignores `xfer_done` and keeps the bus while its `loc_req` bit is 1. The edge that samples `loc_req` at 0 clears its `grant` and `breq` and releases `busy_n`.
- R8: Priority is fixed with index 0 highest. In chain mode, `prio_ok[0]` is 1. `prio_ok[i+1]` is `prio_ok[i]` gated by `breq[i]` being 0. With only master 1 requesting among three masters, `prio_ok` is 3'b011.
- R9: A unit whose `loc_req` drops before it owns the bus returns to idle on that edge, and its `breq` bit falls.
- R10: An owner that gives up the bus because it lost priority, while its `loc_req` is still 1, keeps `breq` high and waits to own the bus again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all arbitration steps on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc_req | input | N_MASTERS | Per-master local request for the bus |
| xfer_done | input | N_MASTERS | Per-master marker of the last cycle of the present transaction |
| grant | output | N_MASTERS | Per-master bus ownership grant |
| breq | output | N_MASTERS | Per-master bus request line |
| prio_ok | output | N_MASTERS | Per-master priority-in line from the resolver |
| busy_n | output | 1 | Shared active-low occupancy line, AND of all drives |

## Verification
Two functions can land on the same edge. A higher-priority master raises its request in the same cycle that the current owner reports the end of its transaction. The bench drives both inputs before one edge. The owner must keep the bus, because the new request is not yet registered and the owner's priority has not yet dropped. The bench then confirms that the bus passes only at the owner's next transaction end. Separately, release and seizure are checked on consecutive edges: the occupancy line rises for exactly one cycle before the waiting master takes the bus.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_REQUEST   = 2'd1,
    ST_WAIT_FREE = 2'd2,
    ST_OWNER     = 2'd3
  } arb_state_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/arb_unit.sv
module arb_unit
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_i,
  input  logic bprn_i,
  input  logic busy_n_i,
  output logic breq_o,
  output logic bpro_o,
  output logic busy_drv_n_o,
  output logic grant_o
);

  arb_state_e state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) state_d = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (!req_i)                   state_d = ST_IDLE;
        else if (bprn_i && busy_n_i)  state_d = ST_OWNER;
        else if (bprn_i)              state_d = ST_WAIT_FREE;
      end
      ST_WAIT_FREE: begin
        if (!req_i)        state_d = ST_IDLE;
        else if (!bprn_i)  state_d = ST_REQUEST;
        else if (busy_n_i) state_d = ST_OWNER;
      end
      ST_OWNER: begin
        if (!req_i)                 state_d = ST_IDLE;
        else if (done_i && !bprn_i) state_d = ST_REQUEST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign breq_o       = (state_q != ST_IDLE);
  assign grant_o      = (state_q == ST_OWNER);
  assign busy_drv_n_o = (state_q != ST_OWNER);
  assign bpro_o       = bprn_i && (state_q == ST_IDLE);

  // R2: request line rises only after a sampled local request
  p_breq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breq_o) |-> $past(req_i));

  // R3: an owner always sees the shared line held low
  p_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> !busy_n_i);

  // R4: priority plus a free line gives the bus on the next edge
  p_seize_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_o && !grant_o && req_i && bprn_i && busy_n_i) |=> grant_o);

  // R5: no seizure while another unit holds the line low
  p_wait_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_o && !busy_n_i) |=> !grant_o);

  // R6: without a transaction end the owner keeps the bus
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && req_i && !done_i) |=> grant_o);

  // R7: dropping the local request frees the bus on the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !req_i) |=> (!grant_o && !breq_o));

endmodule

// File: rtl/arb_prio_net.sv
module arb_prio_net #(
  parameter int N_MASTERS = 3,
  parameter bit CHAIN     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] breq_i,
  input  logic [N_MASTERS-1:0] bpro_i,
  output logic [N_MASTERS-1:0] bprn_o
);

  localparam int LAST = N_MASTERS - 1;

  generate
    if (CHAIN) begin : g_chain
      assign bprn_o[0] = 1'b1;
      for (genvar i = 0; i < LAST; i++) begin : g_link
        assign bprn_o[i+1] = bpro_i[i];
      end
    end else begin : g_parallel
      logic [N_MASTERS:0] lower_req;
      assign lower_req[0] = 1'b0;
      for (genvar i = 0; i < N_MASTERS; i++) begin : g_enc
        assign lower_req[i+1] = lower_req[i] | breq_i[i];
        assign bprn_o[i]      = breq_i[i] & ~lower_req[i];
      end
    end
  endgenerate

  // R8: at most one requesting unit holds priority
  p_single_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bprn_o & breq_i));

endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter #(
  parameter int N_MASTERS = 3,
  parameter bit CHAIN     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] loc_req,
  input  logic [N_MASTERS-1:0] xfer_done,
  output logic [N_MASTERS-1:0] grant,
  output logic [N_MASTERS-1:0] breq,
  output logic [N_MASTERS-1:0] prio_ok,
  output logic                 busy_n
);

  logic                 rst_n_int;
  logic [N_MASTERS-1:0] bpro;
  logic [N_MASTERS-1:0] busy_drv_n;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  arb_prio_net #(.N_MASTERS(N_MASTERS), .CHAIN(CHAIN)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .breq_i (breq),
    .bpro_i (bpro),
    .bprn_o (prio_ok)
  );

  generate
    for (genvar i = 0; i < N_MASTERS; i++) begin : g_unit
      arb_unit u_unit (
        .clk          (clk),
        .rst_n        (rst_n_int),
        .req_i        (loc_req[i]),
        .done_i       (xfer_done[i]),
        .bprn_i       (prio_ok[i]),
        .busy_n_i     (busy_n),
        .breq_o       (breq[i]),
        .bpro_o       (bpro[i]),
        .busy_drv_n_o (busy_drv_n[i]),
        .grant_o      (grant[i])
      );
    end
  endgenerate

  // open-drain occupancy line: any low drive pulls it low
  assign busy_n = &busy_drv_n;

  // R3: a single owner at a time
  p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(grant));

  // R1: reset leaves the line released
  p_reset_line_r1: assert property (@(posedge clk)
    !rst_n_int |-> (busy_n && grant == '0));

endmodule

// File: tb/mm_bus_arbiter_test.sv
module mm_bus_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NM         = 3;
  localparam int NVEC       = 19;

  logic          clk;
  logic          rst_n;
  logic [NM-1:0] loc_req;
  logic [NM-1:0] xfer_done;
  logic [NM-1:0] grant;
  logic [NM-1:0] breq;
  logic [NM-1:0] prio_ok;
  logic          busy_n;

  int n_checks;
  int n_fail;
  bit finished;

  mm_bus_arbiter #(.N_MASTERS(NM), .CHAIN(1'b1)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_req   (loc_req),
    .xfer_done (xfer_done),
    .grant     (grant),
    .breq      (breq),
    .prio_ok   (prio_ok),
    .busy_n    (busy_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {loc_req, xfer_done, exp_grant, exp_breq, exp_busy_n}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'b000, 3'b000, 3'b000, 3'b000, 1'b1},  // 0  R1 idle
    {3'b100, 3'b000, 3'b000, 3'b100, 1'b1},  // 1  R2 m2 requests
    {3'b100, 3'b000, 3'b100, 3'b100, 1'b0},  // 2  R4 m2 seizes
    {3'b101, 3'b100, 3'b100, 3'b101, 1'b0},  // 3  R7 m0 request same edge as m2 done
    {3'b101, 3'b000, 3'b100, 3'b101, 1'b0},  // 4  R6 m2 lost priority, holds
    {3'b101, 3'b100, 3'b000, 3'b101, 1'b1},  // 5  R10 m2 releases, keeps request
    {3'b101, 3'b000, 3'b001, 3'b101, 1'b0},  // 6  R5 m0 takes freed bus
    {3'b101, 3'b001, 3'b001, 3'b101, 1'b0},  // 7  R7 done with priority held
    {3'b100, 3'b000, 3'b000, 3'b100, 1'b1},  // 8  R7 m0 drops request
    {3'b100, 3'b000, 3'b100, 3'b100, 1'b0},  // 9  R4 m2 regains
    {3'b000, 3'b000, 3'b000, 3'b000, 1'b1},  // 10 R7 m2 drops
    {3'b010, 3'b000, 3'b000, 3'b010, 1'b1},  // 11 R2 m1 requests
    {3'b000, 3'b000, 3'b000, 3'b000, 1'b1},  // 12 R9 withdrawn before owning
    {3'b011, 3'b000, 3'b000, 3'b011, 1'b1},  // 13 R2 m0 and m1 together
    {3'b011, 3'b000, 3'b001, 3'b011, 1'b0},  // 14 R8 lowest index wins
    {3'b011, 3'b001, 3'b001, 3'b011, 1'b0},  // 15 R7 done ignored
    {3'b010, 3'b000, 3'b000, 3'b010, 1'b1},  // 16 R7 m0 leaves
    {3'b010, 3'b000, 3'b010, 3'b010, 1'b0},  // 17 R4 m1 seizes
    {3'b000, 3'b000, 3'b000, 3'b000, 1'b1}   // 18 R7 all idle
  };

  function automatic string vec_tag(int k);
    case (k)
      0:                          return "R1";
      1, 11, 13:                  return "R2";
      2, 9, 17:                   return "R4";
      4:                          return "R6";
      5:                          return "R10";
      6:                          return "R5";
      12:                         return "R9";
      14:                         return "R8";
      default:                    return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {grant,breq,busy_n,prio_ok} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NM-1:0] r, input logic [NM-1:0] d);
    loc_req   = r;
    xfer_done = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    loc_req   = '0;
    xfer_done = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, prio_ok: m0 top, no requests -> all pass
    check("R1", {grant, breq, busy_n, prio_ok}, {3'b000, 3'b000, 1'b1, 3'b111});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][12:10], VEC[k][9:7]);
      check(vec_tag(k), {grant, breq, busy_n, prio_ok},
            {VEC[k][6:4], VEC[k][3:1], VEC[k][0], prio_ok});
    end

    // R8 chain: only m1 requesting -> prio_ok 3'b011
    step(3'b010, 3'b000);
    check("R8", {grant, breq, busy_n, prio_ok}, {3'b000, 3'b010, 1'b1, 3'b011});
    step(3'b010, 3'b000);
    check("R8", {grant, breq, busy_n, prio_ok}, {3'b010, 3'b010, 1'b0, 3'b011});
    step(3'b000, 3'b000);
    check("R8", {grant, breq, busy_n, prio_ok}, {3'b000, 3'b000, 1'b1, 3'b111});

    // R6 lost priority in chain: m1 owns, m0 asks, m1 holds without done
    step(3'b010, 3'b000);
    step(3'b010, 3'b000);
    step(3'b011, 3'b000);
    step(3'b011, 3'b000);
    step(3'b011, 3'b000);
    check("R6", {grant, breq, busy_n, prio_ok}, {3'b010, 3'b011, 1'b0, 3'b001});

    // R1 asynchronous reset during ownership
    #1 rst_n = 1'b0;
    #1;
    check("R1", {grant, breq, busy_n, prio_ok}, {3'b000, 3'b000, 1'b1, 3'b111});
    loc_req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {grant, breq, busy_n, prio_ok}, {3'b000, 3'b000, 1'b1, 3'b111});

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule